// File: doc/BRIEF.md
# Exception Frame Stacking Sequencer

This block saves and restores the caller-saved register frame in hardware when an exception is taken and when its handler returns. When an entry request is accepted, it captures eight register values and lowers the chosen stack pointer by one frame. It then writes the frame to memory one word per ready cycle. When a return request is accepted, it reads the frame back from the same stack, drives the recovered values on its outputs and raises that stack pointer by one frame.

Two stack pointers are kept: a main pointer and a process pointer. Only one of them is the visible R13. Thread code uses the process pointer when the stack-select input is high. Any active handler always uses the main pointer, so a nested entry lands on the main stack. The sequencer tracks the nesting depth itself. The final return to thread code uses the stack that the outermost entry chose, even if the select input has changed since then. Arbitration between exception sources, vector fetch and execution belong to neighbouring logic.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset the main pointer equals MSP_INIT, the process pointer equals PSP_INIT, and busy, done and mem_req are low. All restored outputs are zero.
- R2: An accepted entry writes eight words at addresses base, base+4, ..., base+28, where base is the selected pointer minus 32. The words go in the order R0, R1, R2, R3, R12, LR, PC, PSR. Their values are those on the register inputs in the accepting cycle.
- R3: The selected pointer reads 32 less in the cycle after an entry is accepted, and the other pointer is unchanged.
- R4: With no handler active, an entry uses the process pointer when psp_sel is 1 and the main pointer when it is 0. sp_view shows the process pointer only when no handler is active and psp_sel is 1; otherwise it shows the main pointer.
- R5: An entry accepted while a handler is active (nested) always uses the main pointer.
- R6: An accepted return reads eight words at ascending addresses from the selected pointer. It loads them into r0_out, r1_out, r2_out, r3_out, r12_out, lr_out, pc_out and psr_out, in that memory order. By the done cycle that pointer has risen by 32.
- R7: A return from the last active handler uses the pointer chosen by the outermost entry, whatever psp_sel is at the time of the return. Any other return uses the main pointer.
- R8: At most one word moves per cycle: a transfer completes in each cycle where mem_req and mem_ready are both high. While mem_ready is low, the address, write data and direction are held.
- R9: done is high for exactly one cycle, the cycle after the eighth transfer, and busy is low in that cycle.
- R10: Requests that arrive while busy are ignored. A return request with no handler active is ignored, and the block issues no memory traffic for it.
- R11: If entry and return are requested together in an idle cycle, the entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| entry_req | input | 1 | Exception entry request, sampled when idle |
| exit_req | input | 1 | Exception return request, sampled when idle |
| psp_sel | input | 1 | Thread code uses the process stack when high |
| r0_in | input | 32 | Current R0 |
| r1_in | input | 32 | Current R1 |
| r2_in | input | 32 | Current R2 |
| r3_in | input | 32 | Current R3 |
| r12_in | input | 32 | Current R12 |
| lr_in | input | 32 | Current link register |
| pc_in | input | 32 | Current return address |
| psr_in | input | 32 | Current status word |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | High for write, low for read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the ready cycle |
| mem_ready | input | 1 | Transfer completes this cycle when high |
| r0_out | output | 32 | Restored R0 |
| r1_out | output | 32 | Restored R1 |
| r2_out | output | 32 | Restored R2 |
| r3_out | output | 32 | Restored R3 |
| r12_out | output | 32 | Restored R12 |
| lr_out | output | 32 | Restored link register |
| pc_out | output | 32 | Restored return address |
| psr_out | output | 32 | Restored status word |
| msp | output | 32 | Main stack pointer |
| psp | output | 32 | Process stack pointer |
| sp_view | output | 32 | Pointer currently visible as R13 |
| busy | output | 1 | A frame transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame transfer |

## Verification
Some internal faults show up within a single cycle. A wrong frame base or slot counter gives a bad mem_addr on the first or next handshake. A snapshot that captured at the wrong time gives a bad mem_wdata. A stall leak shows as an address that moves while mem_ready is low. Faults in nesting depth or in the remembered thread-stack choice stay hidden until a later entry or return. They then appear as traffic against the wrong pointer at that operation's first transfer. They can also appear as a pointer that fails to return to its reset value after balanced entries and returns. Priority or busy-gating faults appear at once as a transfer the scoreboard did not expect, or as reads where writes were due.

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
  localparam int unsigned XLEN        = 32;
  localparam int unsigned FRAME_WORDS = 8;
  localparam int unsigned WORD_BYTES  = XLEN / 8;
  localparam int unsigned FRAME_BYTES = FRAME_WORDS * WORD_BYTES;
  localparam int unsigned IDX_W       = $clog2(FRAME_WORDS);

  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_POP  = 2'd2
  } seq_state_e;

  // Full-descending stack: the frame base sits one frame below the pointer.
  function automatic word_t push_base(input word_t sp);
    return sp - word_t'(FRAME_BYTES);
  endfunction

  function automatic word_t pop_top(input word_t sp);
    return sp + word_t'(FRAME_BYTES);
  endfunction

  function automatic word_t slot_addr(input word_t base, input logic [IDX_W-1:0] idx);
    return base + word_t'(idx) * word_t'(WORD_BYTES);
  endfunction
endpackage

// File: rtl/exc_sp_bank.sv
module exc_sp_bank
  import exc_frame_pkg::*;
#(
  parameter word_t MSP_INIT = 32'h2000_0800,
  parameter word_t PSP_INIT = 32'h2000_1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dec_en,
  input  logic  dec_psp,
  input  logic  inc_en,
  input  logic  inc_psp,
  output word_t msp,
  output word_t psp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msp <= MSP_INIT;
      psp <= PSP_INIT;
    end else begin
      if (dec_en) begin
        if (dec_psp) psp <= push_base(psp);
        else         msp <= push_base(msp);
      end else if (inc_en) begin
        if (inc_psp) psp <= pop_top(psp);
        else         msp <= pop_top(msp);
      end
    end
  end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_frame_pkg::*;
#(
  parameter int unsigned NEST_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_req,
  input  logic              exit_req,
  input  logic              psp_sel,
  input  logic              mem_ready,
  input  word_t             msp,
  input  word_t             psp,
  output seq_state_e        state,
  output logic [IDX_W-1:0]  idx,
  output word_t             base,
  output logic              acc_entry,
  output logic              acc_exit,
  output logic              entry_psp,
  output logic              xfer,
  output logic              xfer_last,
  output logic              pop_end,
  output logic              done,
  output logic              cur_psp,
  output logic [NEST_W-1:0] depth
);
  localparam logic [NEST_W-1:0] NEST_MAX  = '1;
  localparam logic [IDX_W-1:0]  LAST_SLOT = IDX_W'(FRAME_WORDS - 1);

  logic idle;
  logic exit_psp;
  logic thr_psp;

  assign idle      = (state == SEQ_IDLE);
  assign acc_entry = idle && entry_req && (depth != NEST_MAX);
  assign acc_exit  = idle && exit_req && !acc_entry && (depth != '0);
  assign entry_psp = (depth == '0) && psp_sel;
  assign exit_psp  = (depth == NEST_W'(1)) && thr_psp;
  assign xfer      = !idle && mem_ready;
  assign xfer_last = xfer && (idx == LAST_SLOT);
  assign pop_end   = xfer_last && (state == SEQ_POP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= SEQ_IDLE;
      idx     <= '0;
      base    <= '0;
      depth   <= '0;
      thr_psp <= 1'b0;
      cur_psp <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= xfer_last;
      if (acc_entry) begin
        state   <= SEQ_PUSH;
        idx     <= '0;
        base    <= push_base(entry_psp ? psp : msp);
        cur_psp <= entry_psp;
        if (depth == '0) thr_psp <= psp_sel;
      end else if (acc_exit) begin
        state   <= SEQ_POP;
        idx     <= '0;
        base    <= exit_psp ? psp : msp;
        cur_psp <= exit_psp;
      end else if (xfer) begin
        idx <= idx + IDX_W'(1);
        if (xfer_last) begin
          state <= SEQ_IDLE;
          depth <= (state == SEQ_PUSH) ? depth + NEST_W'(1) : depth - NEST_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/exc_frame_store.sv
module exc_frame_store
  import exc_frame_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              capture,
  input  logic [FRAME_WORDS-1:0][XLEN-1:0]  in_word,
  input  logic [IDX_W-1:0]                  rd_idx,
  input  logic                              load_en,
  input  logic [IDX_W-1:0]                  load_idx,
  input  word_t                             load_data,
  output word_t                             wdata,
  output logic [FRAME_WORDS-1:0][XLEN-1:0]  out_word
);
  logic [FRAME_WORDS-1:0][XLEN-1:0] snap;
  logic [FRAME_WORDS-1:0]           load_hit;

  for (genvar s = 0; s < FRAME_WORDS; s++) begin : g_hit
    assign load_hit[s] = load_en && (load_idx == IDX_W'(s));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap     <= '0;
      out_word <= '0;
    end else begin
      if (capture) snap <= in_word;
      for (int s = 0; s < FRAME_WORDS; s++) begin
        if (load_hit[s]) out_word[s] <= load_data;
      end
    end
  end

  assign wdata = snap[rd_idx];
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_frame_pkg::*;
#(
  parameter int unsigned NEST_W   = 3,
  parameter word_t       MSP_INIT = 32'h2000_0800,
  parameter word_t       PSP_INIT = 32'h2000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_req,
  input  logic            exit_req,
  input  logic            psp_sel,
  input  logic [XLEN-1:0] r0_in,
  input  logic [XLEN-1:0] r1_in,
  input  logic [XLEN-1:0] r2_in,
  input  logic [XLEN-1:0] r3_in,
  input  logic [XLEN-1:0] r12_in,
  input  logic [XLEN-1:0] lr_in,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] psr_in,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ready,
  output logic [XLEN-1:0] r0_out,
  output logic [XLEN-1:0] r1_out,
  output logic [XLEN-1:0] r2_out,
  output logic [XLEN-1:0] r3_out,
  output logic [XLEN-1:0] r12_out,
  output logic [XLEN-1:0] lr_out,
  output logic [XLEN-1:0] pc_out,
  output logic [XLEN-1:0] psr_out,
  output logic [XLEN-1:0] msp,
  output logic [XLEN-1:0] psp,
  output logic [XLEN-1:0] sp_view,
  output logic            busy,
  output logic            done
);
  seq_state_e                       state;
  logic [IDX_W-1:0]                 idx;
  word_t                            base;
  logic                             acc_entry;
  logic                             acc_exit;
  logic                             entry_psp;
  logic                             xfer;
  logic                             xfer_last;
  logic                             pop_end;
  logic                             cur_psp;
  logic [NEST_W-1:0]                depth;
  logic                             in_handler;
  logic                             pop_load;
  logic [FRAME_WORDS-1:0][XLEN-1:0] frame_in;
  logic [FRAME_WORDS-1:0][XLEN-1:0] frame_out;

  // Memory slot order, index 0 at the lowest address.
  assign frame_in = {psr_in, pc_in, lr_in, r12_in, r3_in, r2_in, r1_in, r0_in};

  exc_seq_ctrl #(.NEST_W(NEST_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .entry_req (entry_req),
    .exit_req  (exit_req),
    .psp_sel   (psp_sel),
    .mem_ready (mem_ready),
    .msp       (msp),
    .psp       (psp),
    .state     (state),
    .idx       (idx),
    .base      (base),
    .acc_entry (acc_entry),
    .acc_exit  (acc_exit),
    .entry_psp (entry_psp),
    .xfer      (xfer),
    .xfer_last (xfer_last),
    .pop_end   (pop_end),
    .done      (done),
    .cur_psp   (cur_psp),
    .depth     (depth)
  );

  exc_sp_bank #(.MSP_INIT(MSP_INIT), .PSP_INIT(PSP_INIT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_en  (acc_entry),
    .dec_psp (entry_psp),
    .inc_en  (pop_end),
    .inc_psp (cur_psp),
    .msp     (msp),
    .psp     (psp)
  );

  assign pop_load = xfer && (state == SEQ_POP);

  exc_frame_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (acc_entry),
    .in_word   (frame_in),
    .rd_idx    (idx),
    .load_en   (pop_load),
    .load_idx  (idx),
    .load_data (mem_rdata),
    .wdata     (mem_wdata),
    .out_word  (frame_out)
  );

  assign busy       = (state != SEQ_IDLE);
  assign mem_req    = busy;
  assign mem_we     = (state == SEQ_PUSH);
  assign mem_addr   = slot_addr(base, idx);
  assign in_handler = (depth != '0);
  assign sp_view    = (!in_handler && psp_sel) ? psp : msp;

  assign r0_out  = frame_out[0];
  assign r1_out  = frame_out[1];
  assign r2_out  = frame_out[2];
  assign r3_out  = frame_out[3];
  assign r12_out = frame_out[4];
  assign lr_out  = frame_out[5];
  assign pc_out  = frame_out[6];
  assign psr_out = frame_out[7];
endmodule

// File: rtl/exc_frame_chk.sv
module exc_frame_chk
  import exc_frame_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  mem_req,
  input logic  mem_we,
  input logic  mem_ready,
  input word_t mem_addr,
  input word_t mem_wdata,
  input logic  busy,
  input logic  done,
  input logic  acc_entry,
  input logic  acc_exit,
  input logic  xfer_last,
  input logic  pop_end,
  input logic  in_handler,
  input word_t msp,
  input word_t psp
);
  localparam word_t FB = word_t'(FRAME_BYTES);
  localparam word_t WB = word_t'(WORD_BYTES);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !xfer_last) |=> (mem_req && mem_addr == $past(mem_addr) + WB));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r3_entry_dec: assert property (@(posedge clk) disable iff (!rst_n)
    acc_entry |=> ((msp == $past(msp) - FB && psp == $past(psp)) ||
                   (psp == $past(psp) - FB && msp == $past(msp))));

  a_r5_nested_main: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_entry && in_handler) |=> (psp == $past(psp)));

  a_r6_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pop_end |=> ((msp == $past(msp) + FB && psp == $past(psp)) ||
                 (psp == $past(psp) + FB && msp == $past(msp))));

  a_r11_entry_first: assert property (@(posedge clk) disable iff (!rst_n)
    acc_entry |-> !acc_exit);
endmodule

bind exc_frame_seq exc_frame_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .busy       (busy),
  .done       (done),
  .acc_entry  (acc_entry),
  .acc_exit   (acc_exit),
  .xfer_last  (xfer_last),
  .pop_end    (pop_end),
  .in_handler (in_handler),
  .msp        (msp),
  .psp        (psp)
);

// File: tb/exc_frame_seq_bench.sv
module exc_frame_seq_bench;
  localparam int          CLK_PERIOD = 10;
  localparam int          WATCHDOG   = 20000;
  localparam logic [31:0] MSP0       = 32'h2000_0800;
  localparam logic [31:0] PSP0       = 32'h2000_1000;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        entry_req = 1'b0;
  logic        exit_req = 1'b0;
  logic        psp_sel = 1'b0;
  logic [31:0] ri [8];
  logic [31:0] ro [8];
  logic        mem_req, mem_we, mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] msp, psp, sp_view;
  logic        busy, done;
  logic [31:0] mem [2048];

  int n_chk = 0;
  int n_fail = 0;
  int stall_mode = 0;
  int cyc = 0;
  int done_cnt = 0;
  logic exp_done = 1'b0;

  sb_item_t         sb [$];
  logic [7:0][31:0] fstack [$];
  logic [31:0]      b_msp = MSP0, b_psp = PSP0;
  int               b_depth = 0;
  logic             b_thr = 1'b0;

  assign mem_rdata = mem[mem_addr[12:2]];

  exc_frame_seq #(.MSP_INIT(MSP0), .PSP_INIT(PSP0)) u_exc_frame_seq (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .exit_req(exit_req), .psp_sel(psp_sel),
    .r0_in(ri[0]), .r1_in(ri[1]), .r2_in(ri[2]), .r3_in(ri[3]),
    .r12_in(ri[4]), .lr_in(ri[5]), .pc_in(ri[6]), .psr_in(ri[7]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .r0_out(ro[0]), .r1_out(ro[1]), .r2_out(ro[2]), .r3_out(ro[3]),
    .r12_out(ro[4]), .lr_out(ro[5]), .pc_out(ro[6]), .psr_out(ro[7]),
    .msp(msp), .psp(psp), .sp_view(sp_view), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: sets ready for the coming edge and compares each handshake with the scoreboard.
  always @(negedge clk) begin
    sb_item_t it;
    cyc++;
    if (rst_n) begin
      check(exp_done ? "R9 done pulse" : "R9 no stray done", {31'd0, done}, {31'd0, exp_done});
      if (exp_done) check("R9 busy low at done", {31'd0, busy}, 32'd0);
      exp_done = 1'b0;
      if (done) done_cnt++;
      mem_ready = (stall_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
      if (mem_req && mem_ready) begin
        if (sb.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R10 unexpected transfer: actual addr %h expected none", mem_addr);
        end else begin
          it = sb.pop_front();
          check(it.we ? "R2 write address" : "R6 read address", mem_addr, it.addr);
          check("R8 direction", {31'd0, mem_we}, {31'd0, it.we});
          if (it.we) begin
            check("R2 write data", mem_wdata, it.data);
            mem[mem_addr[12:2]] = mem_wdata;
          end
          if (sb.size() == 0) exp_done = 1'b1;
        end
      end
    end
  end

  task automatic wait_done(input int start);
    while (done_cnt == start) @(negedge clk);
    @(negedge clk);
    check("R9 frame complete", sb.size(), 32'd0);
  endtask

  task automatic do_entry(input logic sel, input logic [31:0] seed, input bit poke, input bit both);
    logic [7:0][31:0] v;
    logic             use_p;
    logic [31:0]      base;
    int               start;
    start = done_cnt;
    for (int k = 0; k < 8; k++) begin
      v[k] = seed + 32'(k) * 32'h0101_0101;
      ri[k] = v[k];
    end
    psp_sel = sel;
    use_p = (b_depth == 0) && sel;
    base = (use_p ? b_psp : b_msp) - 32'd32;
    if (use_p) b_psp = base; else b_msp = base;
    if (b_depth == 0) b_thr = sel;
    b_depth++;
    for (int k = 0; k < 8; k++) sb.push_back('{1'b1, base + 32'(4 * k), v[k]});
    fstack.push_back(v);
    entry_req = 1'b1;
    exit_req = both;
    @(negedge clk);
    entry_req = 1'b0;
    exit_req = 1'b0;
    for (int k = 0; k < 8; k++) ri[k] = ~v[k];
    check(use_p ? "R3 R4 psp lowered" : "R3 R5 msp lowered", use_p ? psp : msp, base);
    check("R3 other pointer kept", use_p ? msp : psp, use_p ? b_msp : b_psp);
    if (poke) begin
      @(negedge clk);
      entry_req = 1'b1;
      exit_req = 1'b1;
      @(negedge clk);
      entry_req = 1'b0;
      exit_req = 1'b0;
    end
    wait_done(start);
    check("R10 msp after busy requests", msp, b_msp);
    check("R10 psp after busy requests", psp, b_psp);
  endtask

  task automatic do_exit(input string tag);
    logic [7:0][31:0] v;
    logic             use_p;
    logic [31:0]      base;
    int               start;
    if (b_depth == 0) begin
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      for (int k = 0; k < 3; k++) begin
        check("R10 exit at depth zero busy", {31'd0, busy}, 32'd0);
        check("R10 exit at depth zero mem_req", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
      end
      check("R10 msp kept", msp, b_msp);
      check("R10 psp kept", psp, b_psp);
      return;
    end
    start = done_cnt;
    use_p = (b_depth == 1) && b_thr;
    v = fstack.pop_back();
    base = use_p ? b_psp : b_msp;
    for (int k = 0; k < 8; k++) sb.push_back('{1'b0, base + 32'(4 * k), v[k]});
    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    wait_done(start);
    if (use_p) b_psp = base + 32'd32; else b_msp = base + 32'd32;
    b_depth--;
    for (int k = 0; k < 8; k++) check({tag, " R6 restored word"}, ro[k], v[k]);
    check({tag, " R6 msp"}, msp, b_msp);
    check({tag, " R6 psp"}, psp, b_psp);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) ri[k] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 msp", msp, MSP0);
    check("R1 psp", psp, PSP0);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 mem_req", {31'd0, mem_req}, 32'd0);
    check("R1 restored r0", ro[0], 32'd0);
    check("R1 restored psr", ro[7], 32'd0);
    psp_sel = 1'b1;
    #1;
    check("R4 thread view process", sp_view, PSP0);

    stall_mode = 0;
    do_entry(1'b1, 32'hA000_0010, 1'b0, 1'b0);      // R4 thread entry on process stack
    check("R4 handler view main", sp_view, b_msp);

    stall_mode = 1;
    do_entry(1'b1, 32'hB100_0020, 1'b1, 1'b0);      // R5 nested on main, R8 stalls, R10 busy poke
    do_exit("R8");                                  // nested return with stalls
    psp_sel = 1'b0;
    do_exit("R7");                                  // final return still uses process stack
    do_exit("R10");                                 // ignored, nothing active

    stall_mode = 0;
    do_entry(1'b0, 32'hC200_0030, 1'b0, 1'b0);      // R4 main stack when select low
    do_entry(1'b0, 32'hD300_0040, 1'b0, 1'b1);      // R11 entry wins over return
    do_exit("R11");
    do_exit("R4");
    check("R6 msp balanced", msp, MSP0);
    check("R6 psp balanced", psp, PSP0);

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule